// File: doc/BRIEF.md
# Self-Clocked Serial Result Transmitter

This block sits beside a successive-approximation converter. It sends the finished result of the last conversion over a two-wire serial link, and it makes the link clock itself. A one-cycle convert command does two things. It tells the converter to begin the next sample, and it starts the transmission of the result that the converter already holds. The result of conversion n-1 therefore travels while conversion n runs.

At the command the block captures three things: the result word, the output coding choice and a tag level. After a fixed lead time it produces a burst of exactly `WIDTH` clock pulses and shifts the word out most significant bit first. Each bit changes only on a falling edge, so it stays steady through the whole high phase of its pulse. Between bursts the clock rests low and the data line shows the captured tag. Timing is set in system-clock cycles: `LEAD_CYC` from command to first rising edge, and `HALF_CYC` for each clock phase. The defaults give about 450 ns lead and 440 ns period at 200 MHz.

Top module: `adc_serial_tx`

## Requirements
- R1: After reset, `sclk_o` and `sdata_o` are both low.
- R2: A command seen at clock edge k while the block is idle starts a transfer. The first rising edge of `sclk_o` is driven at edge k+`LEAD_CYC`.
- R3: A transfer gives exactly `WIDTH` pulses. Each pulse is high for `HALF_CYC` cycles, and the pulses are separated by low phases of `HALF_CYC` cycles. `sclk_o` is low whenever no transfer is running.
- R4: Bits leave most significant first. Pulse j (counting from 0) carries bit `WIDTH-1-j` of the coded word, and the first bit appears on `sdata_o` at edge k.
- R5: `sdata_o` never changes while `sclk_o` is high. It changes only at edge k or on a falling edge of `sclk_o`.
- R6: With `fmt_sb_i` = 1 the coded word is the result unchanged (straight binary). Inputs 0xFFF, 0x800 and 0x000 are sent as 0xFFF, 0x800 and 0x000.
- R7: With `fmt_sb_i` = 0 the coded word is the result with its most significant bit inverted (two's complement). Inputs 0xFFF, 0x800 and 0x000 are sent as 0x7FF, 0x000 and 0x800.
- R8: `tag_i` is captured at edge k. From the last falling edge until the next accepted command, `sdata_o` holds that captured level, whatever `tag_i` does in the meantime. Before the first command it holds 0.
- R9: A command that arrives during a transfer is ignored. The running transfer keeps its timing and its word, and no pulses are added.
- R10: `result_i`, `fmt_sb_i` and `tag_i` are used only at edge k. Changing them later has no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_cmd_i | input | 1 | Convert command, one cycle high |
| result_i | input | WIDTH | Previous conversion result, straight binary |
| fmt_sb_i | input | 1 | 1 = straight binary, 0 = two's complement |
| tag_i | input | 1 | Level to park on the data line after the burst |
| sclk_o | output | 1 | Generated data clock |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
The assertions assume that `conv_cmd_i`, `result_i`, `fmt_sb_i` and `tag_i` are synchronous to `clk`. They also assume that the result and format are valid in the cycle the command is accepted, because the reference word is formed from those sampled values. The stimulus changes every input on the falling edge of `clk` and holds each command for a single cycle. Commands during a burst, and input changes during a burst, are applied on purpose to show that they have no effect.

// File: rtl/adc_tx_pkg.sv
`timescale 1ns/1ps
package adc_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_HIGH = 2'd2,
    ST_LOW  = 2'd3
  } tx_state_e;

  // top bit after coding: kept for straight binary, flipped for two's complement
  function automatic logic code_top_bit(input logic raw_msb, input logic sb_sel);
    return sb_sel ? raw_msb : ~raw_msb;
  endfunction

endpackage

// File: rtl/adc_tx_timer.sv
`timescale 1ns/1ps
module adc_tx_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= load_val_i;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/adc_tx_shreg.sv
`timescale 1ns/1ps
module adc_tx_shreg
  import adc_tx_pkg::*;
#(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             last_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             fmt_sb_i,
  input  logic             tag_i,
  output logic             sdata_o
);

  logic [WIDTH-1:0] coded;
  logic [WIDTH-1:0] sr_q;
  logic             tag_q;
  logic             sdata_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_code
    if (i == WIDTH - 1) begin : g_top
      assign coded[i] = code_top_bit(word_i[i], fmt_sb_i);
    end else begin : g_pass
      assign coded[i] = word_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= '0;
      tag_q   <= 1'b0;
      sdata_q <= 1'b0;
    end else if (load_i) begin
      sdata_q <= coded[WIDTH-1];
      sr_q    <= coded << 1;
      tag_q   <= tag_i;
    end else if (shift_i) begin
      sdata_q <= last_i ? tag_q : sr_q[WIDTH-1];
      sr_q    <= sr_q << 1;
    end
  end

  assign sdata_o = sdata_q;

endmodule

// File: rtl/adc_tx_seq.sv
`timescale 1ns/1ps
module adc_tx_seq
  import adc_tx_pkg::*;
#(
  parameter int unsigned WIDTH    = 12,
  parameter int unsigned HALF_CYC = 44,
  parameter int unsigned LEAD_CYC = 90,
  parameter int unsigned CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_i,
  input  logic             expire_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             sh_load_o,
  output logic             sh_shift_o,
  output logic             sh_last_o,
  output logic             sclk_o,
  output logic             busy_o
);

  localparam int unsigned     BIT_W   = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LEAD_LD = CNT_W'(LEAD_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WIDTH - 1);

  tx_state_e        state_q, state_n;
  logic [BIT_W-1:0] bit_q;
  logic             sclk_q;

  assign sh_last_o = (bit_q == LAST_BIT);

  always_comb begin
    state_n    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = HALF_LD;
    sh_load_o  = 1'b0;
    sh_shift_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cmd_i) begin
        state_n    = ST_LEAD;
        tmr_load_o = 1'b1;
        tmr_val_o  = LEAD_LD;
        sh_load_o  = 1'b1;
      end
      ST_LEAD, ST_LOW: if (expire_i) begin
        state_n    = ST_HIGH;
        tmr_load_o = 1'b1;
      end
      ST_HIGH: if (expire_i) begin
        sh_shift_o = 1'b1;
        if (sh_last_o) begin
          state_n = ST_IDLE;
        end else begin
          state_n    = ST_LOW;
          tmr_load_o = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      sclk_q  <= (state_n == ST_HIGH);
      if (sh_load_o)
        bit_q <= '0;
      else if (sh_shift_o)
        bit_q <= bit_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/adc_serial_tx.sv
`timescale 1ns/1ps
module adc_serial_tx #(
  parameter int unsigned WIDTH    = 12,
  parameter int unsigned HALF_CYC = 44,
  parameter int unsigned LEAD_CYC = 90
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_cmd_i,
  input  logic [WIDTH-1:0] result_i,
  input  logic             fmt_sb_i,
  input  logic             tag_i,
  output logic             sclk_o,
  output logic             sdata_o
);

  localparam int unsigned SPAN  = (HALF_CYC > LEAD_CYC) ? HALF_CYC : LEAD_CYC;
  localparam int unsigned CNT_W = $clog2(SPAN + 1);

  logic             tmr_load, tmr_expire;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_last;
  logic             xfer_busy;

  adc_tx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expire_o   (tmr_expire)
  );

  adc_tx_seq #(
    .WIDTH    (WIDTH),
    .HALF_CYC (HALF_CYC),
    .LEAD_CYC (LEAD_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_i      (conv_cmd_i),
    .expire_i   (tmr_expire),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .sh_load_o  (sh_load),
    .sh_shift_o (sh_shift),
    .sh_last_o  (sh_last),
    .sclk_o     (sclk_o),
    .busy_o     (xfer_busy)
  );

  adc_tx_shreg #(.WIDTH(WIDTH)) u_shreg (
    .clk      (clk),
    .rst      (rst),
    .load_i   (sh_load),
    .shift_i  (sh_shift),
    .last_i   (sh_last),
    .word_i   (result_i),
    .fmt_sb_i (fmt_sb_i),
    .tag_i    (tag_i),
    .sdata_o  (sdata_o)
  );

endmodule

// File: rtl/adc_serial_tx_chk.sv
`timescale 1ns/1ps
module adc_serial_tx_chk #(
  parameter int unsigned WIDTH = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_i,
  input logic [WIDTH-1:0] result_i,
  input logic             fmt_sb_i,
  input logic             tag_i,
  input logic             sclk_o,
  input logic             sdata_o,
  input logic             busy
);

  localparam int unsigned IDX_W = $clog2(WIDTH + 1);

  logic             accept;
  logic [WIDTH-1:0] ref_word;
  logic             ref_tag;
  logic             seen;
  logic             sclk_d;
  logic [IDX_W-1:0] nrise;

  assign accept = cmd_i && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_word <= '0;
      ref_tag  <= 1'b0;
      seen     <= 1'b0;
      sclk_d   <= 1'b0;
      nrise    <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (accept) begin
        ref_word <= {result_i[WIDTH-1] ^ ~fmt_sb_i, result_i[WIDTH-2:0]};
        ref_tag  <= tag_i;
        seen     <= 1'b1;
        nrise    <= '0;
      end else if (sclk_o && !sclk_d) begin
        nrise <= nrise + 1'b1;
      end
    end
  end

  // R3: clock rests low outside a transfer
  p_idle_clk_low_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk_o);

  // R5: data steady while the clock is high
  p_data_stable_high_r5: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> $stable(sdata_o));

  // R3: burst length
  p_pulse_count_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (nrise == IDX_W'(WIDTH)));

  // R4: first bit presented at command acceptance
  p_first_bit_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (sdata_o == ref_word[WIDTH-1]));

  // R4, R6, R7: each rising edge carries the next coded bit, MSB first
  p_bit_order_r4: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && !sclk_d) |->
      ((nrise < IDX_W'(WIDTH)) && (sdata_o == ref_word[IDX_W'(WIDTH - 1) - nrise])));

  // R8: captured tag parked between bursts
  p_idle_tag_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && seen) |-> (sdata_o == ref_tag));

endmodule

bind adc_serial_tx adc_serial_tx_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_i    (conv_cmd_i),
  .result_i (result_i),
  .fmt_sb_i (fmt_sb_i),
  .tag_i    (tag_i),
  .sclk_o   (sclk_o),
  .sdata_o  (sdata_o),
  .busy     (xfer_busy)
);

// File: tb/test_adc_serial_tx.sv
`timescale 1ns/1ps
module test_adc_serial_tx;

  localparam int W    = 12;
  localparam int H    = 44;
  localparam int L    = 90;
  localparam int SPAN = L + 2 * H * W + 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd = 1'b0;
  logic [W-1:0] res = '0;
  logic         fmt = 1'b1;
  logic         tag = 1'b0;
  logic         sclk, sdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  adc_serial_tx #(.WIDTH(W), .HALF_CYC(H), .LEAD_CYC(L)) i_adc_serial_tx (
    .clk        (clk),
    .rst        (rst),
    .conv_cmd_i (cmd),
    .result_i   (res),
    .fmt_sb_i   (fmt),
    .tag_i      (tag),
    .sclk_o     (sclk),
    .sdata_o    (sdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_clk(input int n);
    int m = n - L;
    return (n >= L) && (m < 2 * H * W) && ((m % (2 * H)) < H);
  endfunction

  function automatic bit exp_dat(input int n, input logic [W-1:0] word, input bit t);
    int k = (n < L + H) ? 0 : ((n - L - H) / (2 * H)) + 1;
    return (k >= W) ? t : word[W-1-k];
  endfunction

  // one transfer; expected word given by the caller from R6/R7 rules
  task automatic xfer(input logic [W-1:0] word, input bit f, input bit t,
                      input logic [W-1:0] exp_word, input bit disturb, input string tagname);
    int clk_err = 0, dat_err = 0, rises = 0;
    logic [W-1:0] got = '0;
    bit prev = 1'b0;
    int dcyc = L + 2 * H * 5 + 3;
    @(negedge clk);
    res = word; fmt = f; tag = t; cmd = 1'b1;
    for (int n = 0; n <= SPAN; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == 0) cmd = 1'b0;
      if (sclk !== exp_clk(n)) clk_err++;
      if (sdata !== exp_dat(n, exp_word, t)) dat_err++;
      if (sclk && !prev) begin
        rises++;
        got = {got[W-2:0], sdata};
      end
      prev = sclk;
      if (disturb && n == dcyc) begin
        cmd = 1'b1; res = ~word; fmt = ~f; tag = ~t;
      end
      if (disturb && n == dcyc + 1) cmd = 1'b0;
    end
    check(clk_err == 0, {tagname, " R2 R3 clock waveform errors"}, clk_err, 0);
    check(rises == W, {tagname, " R3 pulse count"}, rises, W);
    check(dat_err == 0, {tagname, " R4 R5 data timing errors"}, dat_err, 0);
    check(got == exp_word, {tagname, " R6 R7 word at rising edges"}, got, exp_word);
    check(sdata == t && !sclk, {tagname, " R8 parked tag"}, sdata, t);
  endtask

  task automatic reset_check();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0, "R1 clock after reset", sclk, 0);
    check(sdata == 1'b0, "R1 data after reset", sdata, 0);
  endtask

  // R8: tag_i wiggling with no command leaves the line alone
  task automatic idle_hold(input bit parked);
    int bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      tag = ~tag; res = res + 12'h111; fmt = ~fmt;
      if (sdata !== parked || sclk !== 1'b0) bad++;
    end
    check(bad == 0, "R8 idle tag ignored", bad, 0);
  endtask

  initial begin
    reset_check();
    xfer(12'hFFF, 1'b1, 1'b0, 12'hFFF, 1'b0, "sb_full");
    xfer(12'hFFF, 1'b0, 1'b1, 12'h7FF, 1'b0, "tc_full");
    xfer(12'h800, 1'b1, 1'b0, 12'h800, 1'b0, "sb_mid");
    xfer(12'h800, 1'b0, 1'b1, 12'h000, 1'b0, "tc_mid");
    xfer(12'h000, 1'b0, 1'b1, 12'h800, 1'b0, "tc_zero");
    xfer(12'h000, 1'b1, 1'b0, 12'h000, 1'b0, "sb_zero");
    idle_hold(1'b0);
    // R9 R10: command and input changes mid-burst are ignored
    xfer(12'hA5C, 1'b1, 1'b1, 12'hA5C, 1'b1, "R9_R10_busy_cmd");
    xfer(12'h3C6, 1'b0, 1'b0, 12'hBC6, 1'b1, "R9_R10_busy_cmd_tc");
    idle_hold(1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule